// File: doc/BRIEF.md
# Ramp-Compare Serial Converter Decoder

This block turns several slowly varying analog levels into digital values using a single shared voltage ramp. Each level has its own comparator, and each comparator output is sampled once per bit clock. The block owns the frame timing. A frame is six slots of 32 bit clocks. During the first slot the block drives a pulse that discharges the ramp capacitor. Over the remaining five slots, which give 160 samples, it watches every comparator for the moment its output first drops.

That sample index is a time-to-crossing count. A shared iterative divider scales it against a full-scale count, giving an unsigned fraction with 8 fractional bits. The full-scale count comes from a calibration frame. After a request, the block drives a force-high line for one whole frame, which pushes the calibration channel to the top of the range. The crossing position seen on that channel becomes the new full-scale count. Before the first calibration, the full-scale count is the nominal 160.

The ramp, the comparators and the interval between calibration requests are handled outside this block.

Top module: `ramp_adc_decoder`

## Requirements
- R1: Frames repeat every 192 clocks and the first frame starts on the first clock after reset. `discharge` is high for frame counts 0 to 31 and low for counts 32 to 191.
- R2: Comparator samples taken while `discharge` is high have no effect on any result.
- R3: A channel's position is the window index (0 to 159, counted from frame count 32) of its first low sample. The sample just before the window is taken as high, so a channel that is low at index 0 has position 0. Samples after the first low one are ignored.
- R4: A channel that stays high for the whole window has position 160.
- R5: Each result equals floor(position × 256 / full_scale) as a 16-bit unsigned value. Channel c occupies `result[16c+15:16c]`.
- R6: After reset, full_scale is 160.
- R7: A `cal_req` pulse in any cycle of frame F, including its last cycle, makes `cal_force` high for every cycle of frame F+1 and low otherwise (unless F+1 also saw a request).
- R8: At the end of a calibration frame, full_scale becomes the position of channel 0 (`CAL_CH`), or 1 if that position is 0. A calibration frame produces no results, and the outputs keep their previous values.
- R9: After each non-calibration frame, `result_valid` pulses for exactly one cycle before the next frame ends. All channels change in that same cycle, and `result` does not change in any other cycle.
- R10: During and right after reset, `result` is 0, `result_valid` is 0 and `cal_force` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | NCH | Comparator outputs, one bit per channel |
| cal_req | input | 1 | Request a calibration frame |
| discharge | output | 1 | Ramp discharge pulse, high during slot 1 |
| cal_force | output | 1 | Drives the calibration channel to full scale |
| result | output | NCH*16 | Normalized results, channel 0 in the low bits |
| result_valid | output | 1 | One-cycle strobe when all results update |

## Verification
On every cycle, the assertions check the following:
- the frame restarts with discharge high after its last count;
- a stored crossing position stays fixed once found;
- each divider quotient lies within one step of the exact ratio;
- the force line spans whole frames;
- full_scale never reaches zero;
- results change only under a single-cycle strobe.

Only the bench scenarios can show the actual numbers. These include the positions decoded from the comparator patterns and the effect of noise during discharge and after the first crossing. They also include the full-scale count carried from one calibration into the later results, including the zero-position and never-crossing corners.

// File: rtl/rampadc_pkg.sv
package rampadc_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/ramp_frame_timer.sv
module ramp_frame_timer #(
  parameter int SLOT_BITS = 32,
  parameter int NSLOTS    = 6,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic             discharge,
  output logic             in_win,
  output logic             win_first,
  output logic             frame_end,
  output logic [IDX_W-1:0] idx
);
  localparam int FRAME = SLOT_BITS * NSLOTS;
  localparam int CNT_W = $clog2(FRAME);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] off;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (frame_end) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign discharge = cnt_q < CNT_W'(SLOT_BITS);
  assign in_win    = ~discharge;
  assign win_first = cnt_q == CNT_W'(SLOT_BITS);
  assign frame_end = cnt_q == CNT_W'(FRAME - 1);
  assign off       = cnt_q - CNT_W'(SLOT_BITS);
  assign idx       = IDX_W'(off);

  // R1: the frame restarts with the discharge slot right after its last count
  p_frame_restart_r1: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (discharge && cnt_q == '0));
endmodule

// File: rtl/ramp_edge_find.sv
module ramp_edge_find #(
  parameter int WIN   = 160,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_win,
  input  logic             win_first,
  input  logic [POS_W-1:0] idx,
  input  logic             cmp,
  output logic [POS_W-1:0] pos_now
);
  logic             found_q;
  logic [POS_W-1:0] pos_q;
  logic             found_eff;
  logic             hit;

  assign found_eff = found_q & ~win_first;
  assign hit       = in_win & ~found_eff & ~cmp;
  assign pos_now   = hit ? idx : (found_eff ? pos_q : POS_W'(WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      found_q <= 1'b0;
      pos_q   <= '0;
    end else if (in_win) begin
      if (hit) begin
        found_q <= 1'b1;
        pos_q   <= idx;
      end else if (win_first) begin
        found_q <= 1'b0;
      end
    end
  end

  // R3: once the first low sample is found, later samples leave the position alone
  p_first_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (found_q && in_win && !win_first) |=> $stable(pos_q));
endmodule

// File: rtl/ramp_div.sv
module ramp_div #(
  parameter int NUM_W = 8,
  parameter int FRAC  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_W-1:0]      num,
  input  logic [NUM_W-1:0]      den,
  output logic                  done,
  output logic [NUM_W+FRAC-1:0] quo
);
  localparam int RES_W  = NUM_W + FRAC;
  localparam int STEP_W = $clog2(RES_W + 1);

  logic [NUM_W-1:0]  rem_q;
  logic [RES_W-1:0]  work_q;
  logic [NUM_W-1:0]  den_q;
  logic [NUM_W-1:0]  num_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic              done_q;
  logic [NUM_W:0]    stp;

  // one restoring step: {quotient bit, new remainder}
  function automatic logic [NUM_W:0] div_step(input logic [NUM_W-1:0] r,
                                              input logic b,
                                              input logic [NUM_W-1:0] d);
    logic [NUM_W:0] trial;
    logic [NUM_W:0] diff;
    trial = {r, b};
    diff  = trial - {1'b0, d};
    if (trial >= {1'b0, d}) return {1'b1, diff[NUM_W-1:0]};
    else                    return {1'b0, trial[NUM_W-1:0]};
  endfunction

  assign stp = div_step(rem_q, work_q[RES_W-1], den_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      work_q <= '0;
      den_q  <= '0;
      num_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        work_q <= {num, {FRAC{1'b0}}};
        den_q  <= den;
        num_q  <= num;
        step_q <= STEP_W'(RES_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= stp[NUM_W-1:0];
        work_q <= {work_q[RES_W-2:0], stp[NUM_W]};
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = work_q;

  // R5: quotient lies within one step of the exact scaled ratio
  p_quotient_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ((32'(quo) * 32'(den_q) <= (32'(num_q) << FRAC)) &&
              ((32'(quo) + 32'd1) * 32'(den_q) > (32'(num_q) << FRAC))));
endmodule

// File: rtl/ramp_adc_decoder.sv
module ramp_adc_decoder #(
  parameter int NCH       = 4,
  parameter int SLOT_BITS = 32,
  parameter int NSLOTS    = 6,
  parameter int FRAC      = 8,
  parameter int CAL_CH    = 0
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic [NCH-1:0]                                 cmp_in,
  input  logic                                           cal_req,
  output logic                                           discharge,
  output logic                                           cal_force,
  output logic [NCH*($clog2((NSLOTS-1)*SLOT_BITS+1)+FRAC)-1:0] result,
  output logic                                           result_valid
);
  import rampadc_pkg::*;

  localparam int WIN   = (NSLOTS - 1) * SLOT_BITS;
  localparam int POS_W = $clog2(WIN + 1);
  localparam int RES_W = POS_W + FRAC;
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;

  logic             in_win, win_first, frame_end;
  logic [POS_W-1:0] idx;
  logic [POS_W-1:0] pos_now [NCH];

  ramp_frame_timer #(.SLOT_BITS(SLOT_BITS), .NSLOTS(NSLOTS), .IDX_W(POS_W)) u_timer (
    .clk(clk), .rst(rst), .discharge(discharge), .in_win(in_win),
    .win_first(win_first), .frame_end(frame_end), .idx(idx)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ramp_edge_find #(.WIN(WIN), .POS_W(POS_W)) u_find (
      .clk(clk), .rst(rst), .in_win(in_win), .win_first(win_first),
      .idx(idx), .cmp(cmp_in[g]), .pos_now(pos_now[g])
    );
  end

  // calibration control and full-scale count
  logic             cal_pend_q, cal_act_q;
  logic [POS_W-1:0] fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_pend_q <= 1'b0;
      cal_act_q  <= 1'b0;
      fs_q       <= POS_W'(WIN);
    end else if (frame_end) begin
      cal_act_q  <= cal_pend_q | cal_req;
      cal_pend_q <= 1'b0;
      if (cal_act_q)
        fs_q <= (pos_now[CAL_CH] == '0) ? POS_W'(1) : pos_now[CAL_CH];
    end else if (cal_req) begin
      cal_pend_q <= 1'b1;
    end
  end

  assign cal_force = cal_act_q;

  // sequencer sharing one divider across channels
  seq_state_t       state_q;
  logic [CH_W-1:0]  ch_q;
  logic             div_start_q;
  logic [POS_W-1:0] pos_lat_q [NCH];
  logic [POS_W-1:0] fs_lat_q;
  logic [RES_W-1:0] hold_q [NCH];
  logic [RES_W-1:0] res_q  [NCH];
  logic             valid_q;
  logic             div_done;
  logic [RES_W-1:0] div_quo;
  logic             launch;

  assign launch = frame_end & ~cal_act_q;

  ramp_div #(.NUM_W(POS_W), .FRAC(FRAC)) u_div (
    .clk(clk), .rst(rst), .start(div_start_q), .num(pos_lat_q[ch_q]),
    .den(fs_lat_q), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      ch_q        <= '0;
      div_start_q <= 1'b0;
      fs_lat_q    <= POS_W'(WIN);
      valid_q     <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        pos_lat_q[c] <= '0;
        hold_q[c]    <= '0;
        res_q[c]     <= '0;
      end
    end else begin
      valid_q     <= 1'b0;
      div_start_q <= 1'b0;
      if (launch) begin
        for (int c = 0; c < NCH; c++) pos_lat_q[c] <= pos_now[c];
        fs_lat_q    <= fs_q;
        ch_q        <= '0;
        div_start_q <= 1'b1;
        state_q     <= SQ_BUSY;
      end else if (state_q == SQ_BUSY && div_done) begin
        hold_q[ch_q] <= div_quo;
        if (ch_q == CH_W'(NCH - 1)) begin
          for (int c = 0; c < NCH - 1; c++) res_q[c] <= hold_q[c];
          res_q[NCH-1] <= div_quo;
          valid_q      <= 1'b1;
          state_q      <= SQ_IDLE;
        end else begin
          ch_q        <= ch_q + 1'b1;
          div_start_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign result[g*RES_W +: RES_W] = res_q[g];
  end
  assign result_valid = valid_q;

  // R9: the strobe lasts a single cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  // R9: results move only together with the strobe
  p_result_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));
  // R7: the force line spans whole frames
  p_cal_span_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_force && !frame_end) |=> cal_force);
  p_cal_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_force) |-> $past(frame_end));
  // R8: full-scale count is never zero
  p_fs_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    fs_q != '0);
endmodule

// File: tb/test_ramp_adc_decoder.sv
module test_ramp_adc_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 4;
  localparam int SLOT  = 32;
  localparam int FRAME = 192;
  localparam int WIN   = 160;
  localparam int RW    = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    cmp_in = '0;
  logic              cal_req = 1'b0;
  logic              discharge, cal_force, result_valid;
  logic [NCH*RW-1:0] result;

  int n_chk = 0, n_fail = 0;
  int bc = 0;
  int tgt [NCH];
  int fs_tgt = 150;
  int fs_m = WIN;
  bit pend_m = 0, act_m = 0, exp_pend = 0;
  int exp_v [NCH];
  int last_pub [NCH];
  bit finished = 0;

  ramp_adc_decoder i_ramp_adc_decoder (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .cal_req(cal_req),
    .discharge(discharge), .cal_force(cal_force),
    .result(result), .result_valid(result_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int pos, input int fs);
    return (pos * 256) / fs;
  endfunction

  function automatic int res_of(input int c);
    return int'(result[c*RW +: RW]);
  endfunction

  // one bit clock; entered and left at a falling edge
  task automatic run_cycle(input bit req);
    chk(discharge == (bc < SLOT), "R1 discharge", discharge, bc < SLOT);
    chk(cal_force == act_m, "R7 cal_force", cal_force, act_m);
    if (result_valid) begin
      chk(exp_pend, "R9 unexpected strobe", 1, int'(exp_pend));
      for (int c = 0; c < NCH; c++) begin
        chk(res_of(c) == exp_v[c], "R5 result", res_of(c), exp_v[c]);
        last_pub[c] = exp_v[c];
      end
      exp_pend = 0;
    end
    for (int c = 0; c < NCH; c++) begin
      int t = (c == 0 && act_m) ? fs_tgt : tgt[c];
      int i = bc - SLOT;
      if (bc < SLOT)   cmp_in[c] = 1'($urandom_range(1)); // R2 noise
      else if (i < t)  cmp_in[c] = 1'b1;
      else if (i == t) cmp_in[c] = 1'b0;
      else             cmp_in[c] = 1'($urandom_range(1)); // R3 noise
    end
    cal_req = req;
    if (req) pend_m = 1;
    if (bc == FRAME - 1) begin
      chk(!exp_pend, "R9 strobe missing", int'(exp_pend), 0);
      for (int c = 0; c < NCH; c++)
        chk(res_of(c) == last_pub[c], "R8 results held", res_of(c), last_pub[c]);
      if (act_m) begin
        fs_m = (fs_tgt == 0) ? 1 : fs_tgt;
      end else begin
        exp_pend = 1;
        for (int c = 0; c < NCH; c++) exp_v[c] = ratio(tgt[c], fs_m);
      end
      act_m = pend_m;
      pend_m = 0;
    end
    @(posedge clk);
    bc = (bc + 1) % FRAME;
    @(negedge clk);
    cal_req = 1'b0;
  endtask

  task automatic run_frame(input int req_at);
    for (int k = 0; k < FRAME; k++) run_cycle(k == req_at);
  endtask

  task automatic set_tgt(input int a, input int b, input int c, input int d);
    tgt[0] = a; tgt[1] = b; tgt[2] = c; tgt[3] = d;
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin tgt[c] = 80; last_pub[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(result_valid == 1'b0, "R10 valid", result_valid, 0);
    chk(cal_force == 1'b0, "R10 cal_force", cal_force, 0);
    for (int c = 0; c < NCH; c++)
      chk(res_of(c) == 0, "R10 result", res_of(c), 0);
    rst = 1'b0;
    bc = 0;
    // R6/R3/R4: nominal full scale, mixed positions, start-low and never-low
    set_tgt(10, 50, 100, 159); run_frame(-1);
    set_tgt(0, 160, 1, 80);    run_frame(-1);
    // R7/R8: request late in frame, then a calibration frame
    fs_tgt = 140; set_tgt(20, 30, 40, 50); run_frame(FRAME - 1);
    set_tgt(60, 70, 160, 0); run_frame(-1);
    set_tgt(140, 139, 141, 2); run_frame(-1);
    // R8: zero position during calibration gives full scale 1
    fs_tgt = 0; run_frame(5);
    set_tgt(160, 0, 1, 159); run_frame(-1);
    set_tgt(3, 7, 11, 13); run_frame(-1);
    // R8: calibration at top of range
    fs_tgt = 160; run_frame(100);
    set_tgt(0, 40, 120, 160); run_frame(-1);
    // random frames with occasional calibration
    for (int f = 0; f < 30; f++) begin
      for (int c = 0; c < NCH; c++) tgt[c] = $urandom_range(WIN);
      fs_tgt = $urandom_range(160, 128);
      run_frame(($urandom_range(4) == 0) ? int'($urandom_range(FRAME - 1)) : -1);
    end
    set_tgt(90, 90, 90, 90);
    run_frame(-1);
    run_frame(-1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule